// File: doc/BRIEF.md
# Dual-Threshold Watchdog Reset Controller

This block supervises a clock generator's programming sequence with two timeouts counted in fixed ticks. A long hard timeout guards against a system that never comes back after a clock change. A short soft timeout is the only way a staged PLL band change reaches the PLL. Each expiry pulls an active-low reset pin low for a fixed number of ticks and sets a sticky status flag.

The hard expiry also moves the CPU and bus clock selections to fail-safe settings and emits a pulse that clears the N-programming enables in the register file. A parameterizable prescaler derives the tick from the system clock. Control fields come in as levels from the register file. Arming is a single-cycle write strobe that counts only while the watchdog enable is 1.

Top module: `wdog_reset_ctrl`

## Requirements
- R1: A cycle with `wd_arm`=1 and `wd_enable`=1 is a trigger. A trigger clears both flags, both tick counters, the safe mode and the reset hold, and restarts the prescaler so that tick k after a trigger is consumed on clock edge trigger+k·TICK_DIV. A cycle with `wd_arm`=1 and `wd_enable`=0 changes nothing.
- R2: `hard_flag` rises on the edge that consumes tick number `hard_limit` after a trigger. It stays 1 until the next trigger.
- R3: With `soft_enable`=1, `soft_flag` rises on the edge that consumes tick number `soft_limit`. With `soft_enable`=0 it never rises. It stays 1 until the next trigger.
- R4: `rst_pin_n` is 1 after reset. It falls on the edge of each expiry and rises again RST_TICKS ticks later, that is RST_TICKS·TICK_DIV cycles after the fall.
- R5: `cpu_band` follows an internal active band that is 0 after reset. Only a soft expiry copies `sw_band` into the active band, and the result appears on `cpu_band` one cycle after the soft flag.
- R6: `cpu_src` encodes 0 = latched pins, 1 = software band/CFS, 2 = watchdog band/CFS. Outside safe mode it is `cpu_band_src`. One cycle after a hard expiry it follows {`cpu_safe_sel`,`cpu_band_src`}: 00→0, 01→1, 1x→2. When it is 2, `cpu_band`/`cpu_cfs` carry `wd_band`/`wd_cfs`.
- R7: `bus_src` encodes 0 = fixed 66/33, 1 = programmed AFS, 2 = watchdog AFS. Outside safe mode it is `bus_src_sel`. One cycle after a hard expiry it follows {`bus_safe_sel`,`bus_src_sel`} in the same way as R6, and `bus_afs` then carries `bus_afs_wd`.
- R8: `nprog_clear` is high for exactly the one cycle that starts on the hard-expiry edge.
- R9: `fs_latched` captures `fs_pins` during reset. On a hard expiry with `relatch_enable`=1 it captures them again, on the same edge as `hard_flag`.
- R10: While `wd_enable`=0 no tick is counted and no expiry occurs. A limit of 0 disables that alarm.
- R11: `rst_pin_oe` is 1 after reset and equals the inverse of `pin_pd_mode` one cycle after it changes.
- R12: After a hard expiry the watchdog stops until the next trigger. A trigger leaves safe mode, so the selections return to R6/R7 normal mapping one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| wd_enable | input | 1 | watchdog enable level |
| wd_arm | input | 1 | one-cycle strobe: enable bit written |
| soft_enable | input | 1 | soft alarm enable |
| hard_limit | input | HARD_W | hard timeout in ticks |
| soft_limit | input | SOFT_W | soft timeout in ticks |
| relatch_enable | input | 1 | re-capture pins on hard expiry |
| fs_pins | input | FS_W | hardware frequency-select pins |
| pin_pd_mode | input | 1 | 1 = shared pin used as power-down input |
| cpu_safe_sel | input | 1 | CPU safe-mode select bit |
| cpu_band_src | input | 1 | CPU band source (0 pins, 1 software) |
| sw_band | input | BAND_W | pending software band |
| sw_cfs | input | BAND_W | software CPU frequency code |
| wd_band | input | BAND_W | watchdog safe band |
| wd_cfs | input | BAND_W | watchdog safe CPU code |
| bus_safe_sel | input | 1 | bus safe-mode select bit |
| bus_src_sel | input | 1 | bus source (0 fixed, 1 programmed) |
| bus_afs_sw | input | BAND_W | programmed bus frequency code |
| bus_afs_wd | input | BAND_W | watchdog bus frequency code |
| rst_pin_n | output | 1 | active-low reset pin value |
| rst_pin_oe | output | 1 | drive enable of the shared pin |
| hard_flag | output | 1 | sticky hard-alarm status |
| soft_flag | output | 1 | sticky soft-alarm status |
| nprog_clear | output | 1 | pulse clearing N-programming enables |
| fs_latched | output | FS_W | latched pin code |
| cpu_src | output | 2 | CPU selection source |
| cpu_band | output | BAND_W | CPU band in use |
| cpu_cfs | output | BAND_W | CPU code in use |
| bus_src | output | 2 | bus selection source |
| bus_afs | output | BAND_W | bus code in use |

## Verification
The flags, `rst_pin_n`, `nprog_clear` and `fs_latched` change on the edge that consumes the expiring tick, which is trigger + limit·TICK_DIV cycles after the trigger edge. The selection outputs and `cpu_band` change one cycle after that. The bench records the edge index of every trigger. It queues each expected value with its absolute cycle number, and the monitor compares it at the falling clock edge of that cycle. It also checks the cycle just before each transition, so an early or late change by a single cycle is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    CPU_FROM_PINS = 2'd0,
    CPU_FROM_SW   = 2'd1,
    CPU_FROM_WD   = 2'd2
  } cpu_src_e;

  typedef enum logic [1:0] {
    BUS_FIXED = 2'd0,
    BUS_PROG  = 2'd1,
    BUS_WD    = 2'd2
  } bus_src_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/wdog_alarm_timer.sv
module wdog_alarm_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         count_en,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         fire,
  output logic         done
);
  logic [W-1:0] cnt;
  logic         step;

  assign step = count_en && tick && !done;
  assign fire = step && (limit != '0) && ((cnt + 1'b1) == limit);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (fire) done <= 1'b1;
    end
  end

  // R10
  done_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(count_en && tick));
endmodule

// File: rtl/wdog_clk_select.sv
module wdog_clk_select
  import wdog_pkg::*;
#(
  parameter int unsigned BAND_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              safe_mode,
  input  logic              cpu_safe_sel,
  input  logic              cpu_band_src,
  input  logic              bus_safe_sel,
  input  logic              bus_src_sel,
  input  logic [BAND_W-1:0] active_band,
  input  logic [BAND_W-1:0] sw_cfs,
  input  logic [BAND_W-1:0] wd_band,
  input  logic [BAND_W-1:0] wd_cfs,
  input  logic [BAND_W-1:0] bus_afs_sw,
  input  logic [BAND_W-1:0] bus_afs_wd,
  output logic [1:0]        cpu_src,
  output logic [BAND_W-1:0] cpu_band,
  output logic [BAND_W-1:0] cpu_cfs,
  output logic [1:0]        bus_src,
  output logic [BAND_W-1:0] bus_afs
);
  cpu_src_e cpu_nx;
  bus_src_e bus_nx;

  always_comb begin
    if (safe_mode && cpu_safe_sel) cpu_nx = CPU_FROM_WD;
    else if (cpu_band_src)         cpu_nx = CPU_FROM_SW;
    else                           cpu_nx = CPU_FROM_PINS;

    if (safe_mode && bus_safe_sel) bus_nx = BUS_WD;
    else if (bus_src_sel)          bus_nx = BUS_PROG;
    else                           bus_nx = BUS_FIXED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_src  <= CPU_FROM_PINS;
      cpu_band <= '0;
      cpu_cfs  <= '0;
      bus_src  <= BUS_FIXED;
      bus_afs  <= '0;
    end else begin
      cpu_src  <= cpu_nx;
      cpu_band <= (cpu_nx == CPU_FROM_WD) ? wd_band : active_band;
      cpu_cfs  <= (cpu_nx == CPU_FROM_WD) ? wd_cfs  : sw_cfs;
      bus_src  <= bus_nx;
      bus_afs  <= (bus_nx == BUS_WD) ? bus_afs_wd : bus_afs_sw;
    end
  end

  // R6
  wd_src_needs_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_src == CPU_FROM_WD) |-> $past(safe_mode));
  // R7
  bus_wd_needs_safe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_src == BUS_WD) |-> $past(safe_mode));
endmodule

// File: rtl/wdog_reset_ctrl.sv
module wdog_reset_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned TICK_DIV  = 29_000_000,
  parameter int unsigned HARD_W    = 8,
  parameter int unsigned SOFT_W    = 4,
  parameter int unsigned BAND_W    = 3,
  parameter int unsigned FS_W      = 2,
  parameter int unsigned RST_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wd_enable,
  input  logic              wd_arm,
  input  logic              soft_enable,
  input  logic [HARD_W-1:0] hard_limit,
  input  logic [SOFT_W-1:0] soft_limit,
  input  logic              relatch_enable,
  input  logic [FS_W-1:0]   fs_pins,
  input  logic              pin_pd_mode,
  input  logic              cpu_safe_sel,
  input  logic              cpu_band_src,
  input  logic [BAND_W-1:0] sw_band,
  input  logic [BAND_W-1:0] sw_cfs,
  input  logic [BAND_W-1:0] wd_band,
  input  logic [BAND_W-1:0] wd_cfs,
  input  logic              bus_safe_sel,
  input  logic              bus_src_sel,
  input  logic [BAND_W-1:0] bus_afs_sw,
  input  logic [BAND_W-1:0] bus_afs_wd,
  output logic              rst_pin_n,
  output logic              rst_pin_oe,
  output logic              hard_flag,
  output logic              soft_flag,
  output logic              nprog_clear,
  output logic [FS_W-1:0]   fs_latched,
  output logic [1:0]        cpu_src,
  output logic [BAND_W-1:0] cpu_band,
  output logic [BAND_W-1:0] cpu_cfs,
  output logic [1:0]        bus_src,
  output logic [BAND_W-1:0] bus_afs
);
  localparam int unsigned HOLD_W = $clog2(RST_TICKS + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(RST_TICKS);

  logic              trig;
  logic              tick;
  logic              running;
  logic              safe_mode;
  logic              hard_fire, hard_done;
  logic              soft_fire, soft_done;
  logic              any_fire;
  logic [HOLD_W-1:0] hold;
  logic [BAND_W-1:0] active_band;

  assign trig     = wd_arm && wd_enable;
  assign any_fire = hard_fire || soft_fire;

  wdog_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(trig), .tick(tick)
  );

  wdog_alarm_timer #(.W(HARD_W)) u_hard (
    .clk(clk), .rst(rst), .clear(trig),
    .count_en(running && wd_enable), .tick(tick), .limit(hard_limit),
    .fire(hard_fire), .done(hard_done)
  );

  wdog_alarm_timer #(.W(SOFT_W)) u_soft (
    .clk(clk), .rst(rst), .clear(trig),
    .count_en(running && wd_enable && soft_enable), .tick(tick),
    .limit(soft_limit), .fire(soft_fire), .done(soft_done)
  );

  // run state, sticky flags, safe mode and side effects
  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      hard_flag   <= 1'b0;
      soft_flag   <= 1'b0;
      safe_mode   <= 1'b0;
      nprog_clear <= 1'b0;
      active_band <= '0;
      fs_latched  <= fs_pins;
    end else if (trig) begin
      running     <= 1'b1;
      hard_flag   <= 1'b0;
      soft_flag   <= 1'b0;
      safe_mode   <= 1'b0;
      nprog_clear <= 1'b0;
    end else begin
      nprog_clear <= hard_fire;
      if (hard_fire) begin
        running   <= 1'b0;
        hard_flag <= 1'b1;
        safe_mode <= 1'b1;
        if (relatch_enable) fs_latched <= fs_pins;
      end
      if (soft_fire) begin
        soft_flag   <= 1'b1;
        active_band <= sw_band;
      end
    end
  end

  // reset pin pulse stretcher
  always_ff @(posedge clk) begin
    if (rst || trig) begin
      hold      <= '0;
      rst_pin_n <= 1'b1;
    end else if (any_fire) begin
      hold      <= HOLD_INIT;
      rst_pin_n <= 1'b0;
    end else if (tick && hold != '0) begin
      hold      <= hold - 1'b1;
      rst_pin_n <= (hold == HOLD_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rst_pin_oe <= 1'b1;
    else     rst_pin_oe <= !pin_pd_mode;
  end

  wdog_clk_select #(.BAND_W(BAND_W)) u_sel (
    .clk(clk), .rst(rst), .safe_mode(safe_mode),
    .cpu_safe_sel(cpu_safe_sel), .cpu_band_src(cpu_band_src),
    .bus_safe_sel(bus_safe_sel), .bus_src_sel(bus_src_sel),
    .active_band(active_band), .sw_cfs(sw_cfs),
    .wd_band(wd_band), .wd_cfs(wd_cfs),
    .bus_afs_sw(bus_afs_sw), .bus_afs_wd(bus_afs_wd),
    .cpu_src(cpu_src), .cpu_band(cpu_band), .cpu_cfs(cpu_cfs),
    .bus_src(bus_src), .bus_afs(bus_afs)
  );

  // R2
  hard_flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hard_flag) |-> $past(trig));
  // R3
  soft_flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(soft_flag) |-> $past(trig));
  // R4
  rst_low_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_pin_n |-> (hard_flag || soft_flag));
  // R5
  band_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_band) |-> $past(soft_fire));
  // R8
  nprog_with_hard_chk: assert property (@(posedge clk) disable iff (rst)
    nprog_clear |-> (hard_flag && hard_done));
  // R12
  stopped_after_hard_chk: assert property (@(posedge clk) disable iff (rst)
    hard_done |-> !running);
endmodule

// File: tb/wdog_reset_ctrl_tb.sv
module wdog_reset_ctrl_tb;
  localparam int DIV = 4;
  localparam int RT  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wd_enable = 0, wd_arm = 0, soft_enable = 0, relatch_enable = 0;
  logic [7:0] hard_limit = 0;
  logic [3:0] soft_limit = 0;
  logic [1:0] fs_pins = 2'b01;
  logic pin_pd_mode = 0, cpu_safe_sel = 0, cpu_band_src = 0;
  logic bus_safe_sel = 0, bus_src_sel = 0;
  logic [2:0] sw_band = 0, sw_cfs = 0, wd_band = 0, wd_cfs = 0;
  logic [2:0] bus_afs_sw = 0, bus_afs_wd = 0;
  logic rst_pin_n, rst_pin_oe, hard_flag, soft_flag, nprog_clear;
  logic [1:0] fs_latched, cpu_src, bus_src;
  logic [2:0] cpu_band, cpu_cfs, bus_afs;

  always #2.5 clk = ~clk;

  wdog_reset_ctrl #(.TICK_DIV(DIV), .RST_TICKS(RT)) u_dut (.*);

  typedef struct { int cyc; int sig; int val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0, e0 = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int observe(int s);
    case (s)
      0: return int'(rst_pin_n);   1: return int'(rst_pin_oe);
      2: return int'(hard_flag);   3: return int'(soft_flag);
      4: return int'(nprog_clear); 5: return int'(cpu_src);
      6: return int'(cpu_band);    7: return int'(cpu_cfs);
      8: return int'(bus_src);     9: return int'(bus_afs);
      default: return int'(fs_latched);
    endcase
  endfunction

  task automatic want(int c, int s, int v, string r);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      int got;
      e = q.pop_front();
      got = observe(e.sig);
      checks++;
      if (got !== e.val) begin
        errors++;
        $display("FAIL %s cyc %0d sig %0d actual %0d expected %0d",
                 e.req, cyc, e.sig, got, e.val);
      end
    end
  end

  task automatic prep();
    @(negedge clk);
    e0 = cyc + 1;
  endtask

  task automatic arm();
    wd_arm = 1'b1;
    @(negedge clk);
    wd_arm = 1'b0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    prep();
    want(e0, 0, 1, "R4"); want(e0, 1, 1, "R11"); want(e0, 2, 0, "R2");
    want(e0, 3, 0, "R3"); want(e0, 4, 0, "R8"); want(e0, 5, 0, "R6");
    want(e0, 8, 0, "R7"); want(e0, 10, 1, "R9");
    drain();

    // soft then hard, band commit, bus safe
    prep();
    wd_enable = 1; soft_enable = 1; hard_limit = 5; soft_limit = 2;
    cpu_band_src = 1; cpu_safe_sel = 0; sw_band = 3; sw_cfs = 6;
    wd_band = 7; wd_cfs = 1; bus_safe_sel = 1; bus_src_sel = 1;
    bus_afs_sw = 2; bus_afs_wd = 5;
    want(e0+2, 6, 0, "R5"); want(e0+2, 8, 1, "R7"); want(e0+2, 9, 2, "R7");
    want(e0+7, 3, 0, "R3"); want(e0+7, 0, 1, "R4");
    want(e0+8, 3, 1, "R3"); want(e0+8, 0, 0, "R4"); want(e0+8, 2, 0, "R2");
    want(e0+8, 6, 0, "R5"); want(e0+9, 6, 3, "R5");
    want(e0+15, 0, 0, "R4"); want(e0+16, 0, 1, "R4");
    want(e0+19, 2, 0, "R2"); want(e0+19, 4, 0, "R8"); want(e0+19, 8, 1, "R7");
    want(e0+20, 2, 1, "R2"); want(e0+20, 0, 0, "R4"); want(e0+20, 4, 1, "R8");
    want(e0+21, 4, 0, "R8"); want(e0+21, 8, 2, "R7"); want(e0+21, 9, 5, "R7");
    want(e0+21, 5, 1, "R6"); want(e0+21, 6, 3, "R6");
    want(e0+27, 0, 0, "R4"); want(e0+28, 0, 1, "R4");
    want(e0+48, 2, 1, "R12"); want(e0+48, 3, 1, "R3"); want(e0+48, 0, 1, "R12");
    arm();
    drain();

    // retrigger, soft disabled, CPU watchdog safe, pin relatch
    prep();
    soft_enable = 0; cpu_safe_sel = 1; relatch_enable = 1; fs_pins = 2'b10;
    hard_limit = 3;
    want(e0, 2, 0, "R1"); want(e0, 3, 0, "R1"); want(e0+1, 5, 1, "R12");
    want(e0+1, 8, 1, "R12");
    want(e0+8, 3, 0, "R3"); want(e0+8, 0, 1, "R3");
    want(e0+11, 10, 1, "R9"); want(e0+11, 2, 0, "R2");
    want(e0+12, 2, 1, "R2"); want(e0+12, 10, 2, "R9");
    want(e0+13, 5, 2, "R6"); want(e0+13, 6, 7, "R6"); want(e0+13, 7, 1, "R6");
    arm();
    drain();

    // arm while disabled is ignored
    prep();
    wd_enable = 0; hard_limit = 2;
    want(e0+1, 2, 1, "R1"); want(e0+12, 2, 1, "R1");
    arm();
    drain();

    // enable dropped right after a trigger: nothing expires
    prep();
    wd_enable = 1; hard_limit = 2;
    want(e0, 2, 0, "R1"); want(e0+8, 2, 0, "R10"); want(e0+16, 2, 0, "R10");
    want(e0+16, 0, 1, "R10");
    arm();
    wd_enable = 0;
    drain();

    // zero limits disable the alarms
    prep();
    wd_enable = 1; hard_limit = 0; soft_enable = 1; soft_limit = 0;
    want(e0+40, 2, 0, "R10"); want(e0+40, 3, 0, "R10"); want(e0+40, 0, 1, "R10");
    arm();
    drain();

    // shared pin in power-down mode
    prep();
    pin_pd_mode = 1;
    want(e0-1, 1, 1, "R11"); want(e0, 1, 0, "R11");
    drain();
    prep();
    pin_pd_mode = 0;
    want(e0, 1, 1, "R11");
    drain();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule